// File: doc/BRIEF.md
# Write Status Bit Generator

This block drives the eight-bit read-data bus of a byte-wide nonvolatile memory. While an internal program or erase runs, it returns a status byte instead of array contents. The host learns that the write has finished in one of two ways: it polls a bit that shows the inverse of the programmed value (or zero during an erase), or it watches a bit that flips on every read until the operation completes. When the operation ends, the poll bit shows its true value at once. The other bits are held at zero for a configurable settling window, and after that the bus carries normal array data again.

The surrounding command decoder raises `busy` after the final command strobe of a program or erase sequence. At the same time it supplies the operation type and the polling-position bit of the latched program data. The block captures both values when the operation starts, so later changes on those inputs have no effect. Each read is signalled by a one-cycle `rd_stb` pulse.

Top module: `wsb_status_gen`

## Requirements
- R1: While no operation is active and no settling window is running, and also while reset is held, `rd_data` equals `array_data`.
- R2: During a program, `rd_data[7]` is the complement of the captured `prog_bit`.
- R3: During an erase, `rd_data[7]` is 0.
- R4: During any operation, `rd_data[6]` is 1 on the first read and flips after each cycle in which `rd_stb` is high. Cycles without `rd_stb` leave it unchanged, and strobes outside an operation have no effect on it.
- R5: Every new operation restarts `rd_data[6]` at 1, whatever the number of earlier reads. This holds even when `rd_stb` is high in the start cycle.
- R6: During an operation, `rd_data[5:0]` reads 0.
- R7: After `busy` is first sampled low, there is a window of `SETTLE_CYC` cycles. In that window `rd_data[7]` shows the true value: the captured `prog_bit` for a program, or 1 for an erase. `rd_data[6:0]` reads 0.
- R8: After the settling window, `rd_data` returns to `array_data`.
- R9: Status output starts in the cycle after `busy` is first sampled high. `erase_op` and `prog_bit` are captured in that start cycle, and later changes to them are ignored until the next start.
- R10: If `busy` rises during a settling window, a new operation starts and status output resumes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| busy | input | 1 | High while an internal program or erase runs |
| erase_op | input | 1 | 1 = erase, 0 = program; captured at operation start |
| prog_bit | input | 1 | Polling-position bit of the latched program data |
| rd_stb | input | 1 | One-cycle pulse per host read |
| array_data | input | DATA_W | Data read from the memory array |
| rd_data | output | DATA_W | Read-data bus toward the host |

## Verification
Two functions can fall in the same cycle: the restart of the toggle at operation start, and the flip of the toggle on a read strobe. The bench raises `rd_stb` in the very cycle that `busy` is first sampled high. This happens once from the idle state and once in the middle of a settling window. The toggle bit must still read 1 on the first status read. A second overlap is a new operation that arrives while the previous one is still settling. For that case the bench checks that the captured operation type switches over, and that the settling output gives way to fresh status in the following cycle.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

  // Phase of the status generator.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BUSY   = 2'd1,
    PH_SETTLE = 2'd2
  } wsb_phase_e;

endpackage

// File: rtl/wsb_phase_ctrl.sv
module wsb_phase_ctrl
  import wsb_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       erase_in,
  input  logic       pbit_in,
  output wsb_phase_e phase,
  output logic       start,
  output logic       erase_q,
  output logic       pbit_q
);

  localparam int LOAD  = (SETTLE_CYC > 0) ? SETTLE_CYC - 1 : 0;
  localparam int CNT_W = (LOAD > 0) ? $clog2(LOAD + 1) : 1;

  wsb_phase_e       phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cap_en;

  // A new operation starts whenever busy is seen outside the busy phase.
  assign start  = busy && (phase != PH_BUSY);
  assign cap_en = start;

  // Next-state logic.
  always_comb begin
    phase_d = phase;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (busy) phase_d = PH_BUSY;
      end
      PH_BUSY: begin
        if (!busy) begin
          if (SETTLE_CYC > 0) begin
            phase_d = PH_SETTLE;
            cnt_d   = CNT_W'(LOAD);
            cnt_en  = 1'b1;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      PH_SETTLE: begin
        if (busy) begin
          phase_d = PH_BUSY;
        end else if (cnt_q == '0) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      pbit_q  <= 1'b0;
    end else if (cap_en) begin
      erase_q <= erase_in;
      pbit_q  <= pbit_in;
    end
  end

  // R9
  busy_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (phase == PH_BUSY));

  // R9
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BUSY) && !start |=> $stable(erase_q) && $stable(pbit_q));

  // R7
  settle_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETTLE) |-> (cnt_q <= CNT_W'(LOAD)));

  // R10
  settle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETTLE) && busy |-> start);

endmodule

// File: rtl/wsb_toggle.sv
module wsb_toggle
  import wsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  wsb_phase_e phase,
  input  logic       rd_stb,
  output logic       tgl
);

  logic tgl_d;
  logic tgl_en;

  // Start takes priority over a read strobe in the same cycle.
  always_comb begin
    tgl_en = 1'b0;
    tgl_d  = tgl;
    if (start) begin
      tgl_en = 1'b1;
      tgl_d  = 1'b1;
    end else if ((phase == PH_BUSY) && rd_stb) begin
      tgl_en = 1'b1;
      tgl_d  = ~tgl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl <= 1'b1;
    end else if (tgl_en) begin
      tgl <= tgl_d;
    end
  end

  // R5
  tgl_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> tgl);

  // R4
  tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BUSY) && rd_stb && !start |=> (tgl != $past(tgl)));

  // R4
  tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb && !start |=> $stable(tgl));

endmodule

// File: rtl/wsb_status_mux.sv
module wsb_status_mux
  import wsb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  wsb_phase_e        phase,
  input  logic              erase_q,
  input  logic              pbit_q,
  input  logic              tgl,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);

  logic poll_busy;
  logic poll_done;

  assign poll_busy = erase_q ? 1'b0 : ~pbit_q;
  assign poll_done = erase_q ? 1'b1 : pbit_q;

  always_comb begin
    rd_data = '0;
    unique case (phase)
      PH_BUSY: begin
        rd_data[POLL_BIT] = poll_busy;
        rd_data[TOG_BIT]  = tgl;
      end
      PH_SETTLE: begin
        rd_data[POLL_BIT] = poll_done;
      end
      default: rd_data = array_data;
    endcase
  end

endmodule

// File: rtl/wsb_status_gen.sv
module wsb_status_gen
  import wsb_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOG_BIT    = 6,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              erase_op,
  input  logic              prog_bit,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [1:0] rst_sync;
  logic       rst_n_int;
  wsb_phase_e phase;
  logic       start;
  logic       erase_q;
  logic       pbit_q;
  logic       tgl;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync[1];

  wsb_phase_ctrl #(
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .busy     (busy),
    .erase_in (erase_op),
    .pbit_in  (prog_bit),
    .phase    (phase),
    .start    (start),
    .erase_q  (erase_q),
    .pbit_q   (pbit_q)
  );

  wsb_toggle u_tgl (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .start  (start),
    .phase  (phase),
    .rd_stb (rd_stb),
    .tgl    (tgl)
  );

  wsb_status_mux #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT)
  ) u_mux (
    .phase      (phase),
    .erase_q    (erase_q),
    .pbit_q     (pbit_q),
    .tgl        (tgl),
    .array_data (array_data),
    .rd_data    (rd_data)
  );

  // R3
  erase_poll_low_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $past(busy) && busy && erase_q && (phase == PH_BUSY) |-> !rd_data[POLL_BIT]);

  // R2
  prog_poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (phase == PH_BUSY) && !erase_q |-> (rd_data[POLL_BIT] != pbit_q));

  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (phase == PH_IDLE) |-> (rd_data == array_data));

  // R6
  busy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (phase == PH_BUSY) |-> ($countones(rd_data) <= 2));

endmodule

// File: tb/tb_wsb_status_gen.sv
module tb_wsb_status_gen;

  localparam int CLK_P  = 10;
  localparam int SETTLE = 3;
  localparam int NV     = 25;

  // {busy, erase, pbit, stb, array[7:0], expected[7:0], tag[3:0]}
  localparam logic [23:0] VEC [NV] = '{
    {4'b0000, 8'h5A, 8'h5A, 4'd1},
    {4'b1011, 8'h5A, 8'h5A, 4'd9},
    {4'b1001, 8'h33, 8'h40, 4'd2},
    {4'b1001, 8'h33, 8'h00, 4'd4},
    {4'b1000, 8'h33, 8'h40, 4'd4},
    {4'b1000, 8'h33, 8'h40, 4'd4},
    {4'b0001, 8'h33, 8'h40, 4'd6},
    {4'b0000, 8'h33, 8'h80, 4'd7},
    {4'b0000, 8'h33, 8'h80, 4'd7},
    {4'b0000, 8'h33, 8'h80, 4'd7},
    {4'b0000, 8'h33, 8'h33, 4'd8},
    {4'b1100, 8'h33, 8'h33, 4'd1},
    {4'b1001, 8'h33, 8'h40, 4'd3},
    {4'b1001, 8'h33, 8'h00, 4'd3},
    {4'b1001, 8'h33, 8'h40, 4'd4},
    {4'b0000, 8'h33, 8'h00, 4'd4},
    {4'b0000, 8'h33, 8'h80, 4'd7},
    {4'b1001, 8'h33, 8'h80, 4'd10},
    {4'b1001, 8'h33, 8'hC0, 4'd5},
    {4'b1000, 8'h33, 8'h80, 4'd2},
    {4'b0000, 8'h33, 8'h80, 4'd2},
    {4'b0000, 8'h33, 8'h00, 4'd7},
    {4'b0000, 8'h33, 8'h00, 4'd7},
    {4'b0000, 8'h33, 8'h00, 4'd7},
    {4'b0000, 8'hC3, 8'hC3, 4'd8}
  };

  logic       clk;
  logic       rst_n;
  logic       busy;
  logic       erase_op;
  logic       prog_bit;
  logic       rd_stb;
  logic [7:0] array_data;
  logic [7:0] rd_data;

  int n_chk;
  int n_bad;
  bit done;

  wsb_status_gen #(
    .DATA_W(8), .POLL_BIT(7), .TOG_BIT(6), .SETTLE_CYC(SETTLE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .erase_op(erase_op),
    .prog_bit(prog_bit), .rd_stb(rd_stb), .array_data(array_data),
    .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic string tag_name(int k);
    case (k)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input logic [7:0] exp, input string tag);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%02h expected=%02h at %0t", tag, rd_data, exp, $time);
    end
  endtask

  task automatic drive(input logic b, input logic e, input logic p,
                       input logic s, input logic [7:0] a);
    @(negedge clk);
    busy = b; erase_op = e; prog_bit = p; rd_stb = s; array_data = a;
    #1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; busy = 1'b0; erase_op = 1'b0; prog_bit = 1'b0;
    rd_stb = 1'b0; array_data = 8'hA5;
    #(CLK_P * 2 + 1);
    check(8'hA5, "R1");  // reset state passes array data
    @(negedge clk); rst_n = 1'b1;
    repeat (3) drive(1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    check(8'hA5, "R1");

    // table of vectors, one per cycle
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:12]);
      check(VEC[i][11:4], tag_name(int'(VEC[i][3:0])));
    end

    // strobes while idle do not disturb the toggle start value (R4)
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h11);
    check(8'h11, "R4");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h11);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 8'h11);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h11);
    check(8'h40, "R4");  // program of 1, bit6 starts at 1
    check(8'h40, "R6");

    // reset during an operation returns array data immediately (R1)
    @(negedge clk); rst_n = 1'b0; #1;
    check(8'h11, "R1");
    @(negedge clk); rst_n = 1'b1; busy = 1'b0;
    repeat (3) drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h77);
    check(8'h77, "R8");

    // erase with reads, then completion shows 1 then array data
    drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h77);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'h77);
    check(8'h40, "R3");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h77);
    check(8'h00, "R4");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h77);
    check(8'h80, "R7");
    repeat (SETTLE) drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h77);
    check(8'h77, "R8");

    done = 1'b1;
    summary();
  end

endmodule